// File: doc/BRIEF.md
# Pipelined Serial ADC Scan Controller

This block runs an external 10-bit converter that has a serial port, and scans nine analog channels in a fixed round-robin order. It is the SPI master: it drives chip select, serial clock and the outgoing data line, and it reads the returning data line. Each 16-bit full-duplex frame carries the address of the next channel out of the block. In the same frame, the result of the channel addressed one frame earlier comes back in. The block also produces a conversion clock for the converter and accepts an end-of-conversion flag from it.

Between frames the block waits for the conversion to finish. A mode pin selects how it waits. In counted mode it supplies a fixed number of conversion-clock cycles. In flag mode it waits for the converter's end-of-conversion input. A second pin selects whether each frame goes out as one 16-clock burst or as two 8-clock bursts with an idle gap between them. Each returned word is shifted down to a 10-bit sample and presented with a 4-bit channel tag and a one-cycle valid strobe. The serial and conversion clocks are derived from the system clock by a parameterized divider.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is held, and until scanning is enabled, cs_n_o is 1, and sclk_o, cclk_o and smp_valid_o are 0.
- R2: Sample tags run 0, 1, ..., 8 and then wrap back to 0. Tags are never 9 or above.
- R3: Each frame holds cs_n_o low for exactly 16 rising edges of sclk_o. sclk_o idles low and rises at most every 2*DIV system cycles within a burst. mosi_o changes only while sclk_o is low, most significant bit first. Outgoing bits 15:12 carry the channel address and bits 11:0 are zero.
- R4: smp_data_o equals bits 15:6 of the 16-bit word shifted in on miso_i, captured at the rising edges of sclk_o. The six low bits are dropped.
- R5: A sample is published, in the cycle in which cs_n_o rises, for every frame except the first frame after enable. That first result is discarded. The tag is the channel sent in the frame before the one that returned the data.
- R6: With eoc_mode_i = 0, exactly CONV_CYC (44) rising edges of cclk_o occur between the end of one frame and the start of the next. cclk_o changes only while cs_n_o was high.
- R7: With eoc_mode_i = 1, a new frame starts only after eoc_i has been seen low and then high since the previous frame ended. cclk_o stays still in this mode.
- R8: With split_i = 1, sclk_o stays low after the 8th bit while cs_n_o stays low, for GAP_TICKS (4) half-periods. The longest interval between rising edges is then (GAP_TICKS+2)*DIV cycles, and the received data is the same as in one-burst mode.
- R9: Clearing scan_en_i lets the current frame finish and publish its sample, after which no further frame starts. Setting scan_en_i again restarts the scan at channel 0 and discards the first result.
- R10: smp_valid_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en_i | input | 1 | 1 scans continuously; 0 stops after the current frame |
| eoc_mode_i | input | 1 | 0 counted conversion wait, 1 wait on eoc_i |
| split_i | input | 1 | 0 one 16-bit burst, 1 two 8-bit bursts with a gap |
| eoc_i | input | 1 | End-of-conversion flag from the converter |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the converter |
| cclk_o | output | 1 | Conversion clock |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_data_o | output | 10 | Conversion result |
| smp_chan_o | output | 4 | Channel the result belongs to |

## Verification
The bound checker enforces the serial-line discipline on every cycle. It checks that the clock stays low whenever select is high, that data does not move while the clock is high, and that the clock never toggles outside a frame. It also checks that the conversion clock toggles only between frames and stays still in flag mode, and that each sample strobe is a single cycle that lines up with the end of a frame and carries a tag below nine. Only the bench's scenarios can show what depends on content and on the sequence of frames. These are the address order and zero padding seen by a converter model, the pipelined pairing of results with tags, the discarded first frame, the exact count of 44 conversion clocks, the wait for the flag, the gap length in split mode, and the stop and restart when scanning is disabled.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SETUP = 3'd1,
        S_XFER  = 3'd2,
        S_GAP   = 3'd3,
        S_HOLD  = 3'd4,
        S_WAIT  = 3'd5
    } scan_state_e;

endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || wrap) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && wrap;

endmodule

// File: rtl/adc_scan_chan.sv
module adc_scan_chan #(
    parameter int NUM_CH = 9,
    parameter int AW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          step_i,
    output logic [AW-1:0] chan_o
);
    logic [AW-1:0] chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (restart_i) begin
            chan_d = '0;
        end else if (step_i) begin
            if (chan_q == AW'(NUM_CH - 1)) begin
                chan_d = '0;
            end else begin
                chan_d = chan_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign chan_o = chan_q;

endmodule

// File: rtl/adc_scan_eoc.sv
module adc_scan_eoc (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_i,
    input  logic clear_i,
    output logic ready_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic       seen_low;
    } eoc_regs_t;

    eoc_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], eoc_i};
        if (clear_i) begin
            r_d.seen_low = 1'b0;
        end else if (!r_q.sync[1]) begin
            r_d.seen_low = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o = r_q.seen_low && r_q.sync[1];

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
    parameter int DIV       = 2,
    parameter int NUM_CH    = 9,
    parameter int AW        = 4,
    parameter int RW        = 10,
    parameter int FW        = 16,
    parameter int CONV_CYC  = 44,
    parameter int GAP_TICKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en_i,
    input  logic          eoc_mode_i,
    input  logic          split_i,
    input  logic          eoc_i,
    input  logic          miso_i,
    output logic          cs_n_o,
    output logic          sclk_o,
    output logic          mosi_o,
    output logic          cclk_o,
    output logic          smp_valid_o,
    output logic [RW-1:0] smp_data_o,
    output logic [AW-1:0] smp_chan_o
);
    import adc_scan_pkg::*;

    localparam int BCW  = $clog2(FW);
    localparam int HALF = FW / 2;
    localparam int GCW  = $clog2(GAP_TICKS + 1);
    localparam int CCW  = $clog2(CONV_CYC + 1);

    typedef struct packed {
        scan_state_e   st;
        logic          cs_n;
        logic          sclk;
        logic          cclk;
        logic          first;
        logic          valid;
        logic [FW-1:0] tx;
        logic [FW-1:0] rx;
        logic [BCW-1:0] bits;
        logic [GCW-1:0] gap;
        logic [CCW-1:0] conv;
        logic [AW-1:0] sent;
        logic [AW-1:0] tag;
        logic [AW-1:0] otag;
        logic [RW-1:0] odata;
    } regs_t;

    regs_t         r_d, r_q;
    logic          tick;
    logic          launch;
    logic          eoc_clr;
    logic          eoc_ready;
    logic [AW-1:0] chan_cur;

    // Divider: one tick per serial half-period while a scan is active.
    adc_scan_tick #(.DIV(DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.st != S_IDLE),
        .tick_o (tick)
    );

    // Round-robin channel pointer; parked at 0 while idle.
    adc_scan_chan #(.NUM_CH(NUM_CH), .AW(AW)) chan_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i ((r_q.st == S_IDLE) && !launch),
        .step_i    (launch),
        .chan_o    (chan_cur)
    );

    // Synchronized end-of-conversion detector: needs low, then high.
    adc_scan_eoc eoc_det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .eoc_i   (eoc_i),
        .clear_i (eoc_clr),
        .ready_o (eoc_ready)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        launch    = 1'b0;
        eoc_clr   = 1'b0;

        case (r_q.st)
            S_IDLE: begin
                r_d.first = 1'b1;
                if (scan_en_i) begin
                    launch = 1'b1;
                end
            end

            // Half-period of address setup before the first rising edge.
            S_SETUP: begin
                if (tick) begin
                    r_d.st = S_XFER;
                end
            end

            S_XFER: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        r_d.rx   = {r_q.rx[FW-2:0], miso_i};
                    end else begin
                        r_d.sclk = 1'b0;
                        r_d.tx   = {r_q.tx[FW-2:0], 1'b0};
                        r_d.bits = r_q.bits + 1'b1;
                        if (r_q.bits == BCW'(FW - 1)) begin
                            r_d.st = S_HOLD;
                        end else if (split_i && (r_q.bits == BCW'(HALF - 1))) begin
                            r_d.st  = S_GAP;
                            r_d.gap = '0;
                        end
                    end
                end
            end

            // Byte gap: clock parked low, select kept asserted.
            S_GAP: begin
                if (tick) begin
                    if (r_q.gap == GCW'(GAP_TICKS - 1)) begin
                        r_d.st = S_XFER;
                    end else begin
                        r_d.gap = r_q.gap + 1'b1;
                    end
                end
            end

            // Release select and publish the word just received.
            S_HOLD: begin
                if (tick) begin
                    r_d.cs_n  = 1'b1;
                    r_d.valid = !r_q.first;
                    r_d.odata = r_q.rx[FW-1 -: RW];
                    r_d.otag  = r_q.tag;
                    r_d.first = 1'b0;
                    r_d.conv  = '0;
                    r_d.cclk  = 1'b0;
                    eoc_clr   = 1'b1;
                    r_d.st    = scan_en_i ? S_WAIT : S_IDLE;
                end
            end

            S_WAIT: begin
                if (!scan_en_i) begin
                    r_d.st   = S_IDLE;
                    r_d.cclk = 1'b0;
                end else if (eoc_mode_i) begin
                    if (eoc_ready) begin
                        launch = 1'b1;
                    end
                end else if (tick) begin
                    r_d.cclk = !r_q.cclk;
                    if (r_q.cclk) begin
                        if (r_q.conv == CCW'(CONV_CYC - 1)) begin
                            launch = 1'b1;
                        end else begin
                            r_d.conv = r_q.conv + 1'b1;
                        end
                    end
                end
            end

            default: begin
                r_d.st = S_IDLE;
            end
        endcase

        // Frame start: send the current pointer, remember the last one sent.
        if (launch) begin
            r_d.st   = S_SETUP;
            r_d.cs_n = 1'b0;
            r_d.sclk = 1'b0;
            r_d.cclk = 1'b0;
            r_d.bits = '0;
            r_d.tx   = {chan_cur, {(FW - AW){1'b0}}};
            r_d.tag  = r_q.sent;
            r_d.sent = chan_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o      = r_q.cs_n;
    assign sclk_o      = r_q.sclk;
    assign mosi_o      = r_q.tx[FW-1];
    assign cclk_o      = r_q.cclk;
    assign smp_valid_o = r_q.valid;
    assign smp_data_o  = r_q.odata;
    assign smp_chan_o  = r_q.otag;

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
    parameter int NUM_CH = 9,
    parameter int AW     = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n_o,
    input logic          sclk_o,
    input logic          mosi_o,
    input logic          cclk_o,
    input logic          eoc_mode_i,
    input logic          smp_valid_o,
    input logic [AW-1:0] smp_chan_o
);
    // R3: clock idles low whenever select is released
    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R3: outgoing data moves only while the clock is low
    a_r3_mosi_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(mosi_o) |-> !sclk_o);

    // R3: the serial clock toggles only inside a frame
    a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sclk_o) |-> !cs_n_o);

    // R6: conversion clock toggles only between frames
    a_r6_cclk_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(cclk_o) |-> $past(cs_n_o));

    // R7: no conversion clock in flag mode
    a_r7_cclk_still_in_flag_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_mode_i && $past(eoc_mode_i)) |-> $stable(cclk_o));

    // R5: a sample appears exactly as a frame ends
    a_r5_sample_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (cs_n_o && !$past(cs_n_o)));

    // R2: tags stay inside the scanned range
    a_r2_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (smp_chan_o < AW'(NUM_CH)));

    // R10: the strobe lasts one cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o);

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.NUM_CH(NUM_CH), .AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .cclk_o      (cclk_o),
    .eoc_mode_i  (eoc_mode_i),
    .smp_valid_o (smp_valid_o),
    .smp_chan_o  (smp_chan_o)
);

// File: tb/adc_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb_top;
    localparam int DIV       = 2;
    localparam int NCH       = 9;
    localparam int CONV      = 44;
    localparam int GAP       = 4;
    localparam int EOC_DLY   = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic       eoc_mode = 1'b0;
    logic       split = 1'b0;
    logic       eoc = 1'b1;
    logic       miso = 1'b0;
    logic       cs_n, sclk, mosi, cclk, smp_valid;
    logic [9:0] smp_data;
    logic [3:0] smp_chan;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    adc_scan_ctrl #(.DIV(DIV), .CONV_CYC(CONV), .GAP_TICKS(GAP)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_en_i   (scan_en),
        .eoc_mode_i  (eoc_mode),
        .split_i     (split),
        .eoc_i       (eoc),
        .miso_i      (miso),
        .cs_n_o      (cs_n),
        .sclk_o      (sclk),
        .mosi_o      (mosi),
        .cclk_o      (cclk),
        .smp_valid_o (smp_valid),
        .smp_data_o  (smp_data),
        .smp_chan_o  (smp_chan)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (ok !== 1'b1) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] res_of(input int ch, input int sd);
        return 10'((ch * 97 + sd) & 10'h3FF);
    endfunction

    // Session state shared by the converter model, the monitor and tasks.
    int  seed = 0;
    int  exp_tag = 0;
    int  exp_addr = 0;
    int  samples = 0;
    int  frames = 0;
    int  max_int = 0;
    bit  sess_first = 1'b1;

    // Converter model, evaluated between clock edges.
    int          cyc = 0;
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_cclk = 1'b0;
    logic [15:0] sh = '0, rxw = '0;
    int          prev_addr = 0, nrise = 0, last_rise = 0, fmax = 0;
    int          cclk_cnt = 0, eoc_cnt = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_cs && !cs_n) begin
                if (!sess_first) begin
                    if (eoc_mode) begin
                        chk(eoc == 1'b1, "R7 frame before flag", int'(eoc), 1);
                        chk(cclk_cnt == 0, "R7 cclk in flag mode", cclk_cnt, 0);
                    end else begin
                        chk(cclk_cnt == CONV, "R6 conversion clocks", cclk_cnt, CONV);
                    end
                end
                sess_first = 1'b0;
                sh    = {res_of(prev_addr, seed), 6'b0};
                miso  = sh[15];
                eoc   = 1'b0;
                eoc_cnt = 0;
                nrise = 0;
                fmax  = 0;
            end
            if (!cs_n && !p_sclk && sclk) begin
                rxw = {rxw[14:0], mosi};
                if (nrise > 0 && (cyc - last_rise) > fmax) fmax = cyc - last_rise;
                last_rise = cyc;
                nrise++;
            end
            if (!cs_n && p_sclk && !sclk) begin
                sh   = {sh[14:0], 1'b0};
                miso = sh[15];
            end
            if (!p_cs && cs_n) begin
                chk(nrise == 16, "R3 clocks per frame", nrise, 16);
                chk(int'(rxw[15:12]) == exp_addr, "R3 address field", int'(rxw[15:12]), exp_addr);
                chk(rxw[11:0] == 12'h000, "R3 padding zero", int'(rxw[11:0]), 0);
                prev_addr = int'(rxw[15:12]);
                exp_addr  = (exp_addr + 1) % NCH;
                frames++;
                if (fmax > max_int) max_int = fmax;
                eoc_cnt  = EOC_DLY;
                cclk_cnt = 0;
            end
            if (!p_cclk && cclk) cclk_cnt++;
            if (eoc_cnt > 0) begin
                eoc_cnt--;
                if (eoc_cnt == 0) eoc = 1'b1;
            end
        end
        p_cs   = cs_n;
        p_sclk = sclk;
        p_cclk = cclk;
    end

    // Sample monitor.
    logic p_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            chk(!p_valid, "R10 single-cycle strobe", int'(p_valid), 0);
            chk(int'(smp_chan) == exp_tag, "R2/R5 tag order", int'(smp_chan), exp_tag);
            chk(smp_data == res_of(int'(smp_chan), seed), "R4 result alignment",
                int'(smp_data), int'(res_of(int'(smp_chan), seed)));
            exp_tag = (exp_tag + 1) % NCH;
            samples++;
        end
        p_valid = smp_valid;
    end

    task automatic start_session(input bit m_eoc, input bit m_split, input int sd);
        @(negedge clk);
        eoc_mode   = m_eoc;
        split      = m_split;
        seed       = sd;
        exp_tag    = 0;
        exp_addr   = 0;
        samples    = 0;
        frames     = 0;
        max_int    = 0;
        sess_first = 1'b1;
        scan_en    = 1'b1;
    endtask

    task automatic wait_samples(input int n);
        while (samples < n) @(negedge clk);
    endtask

    task automatic stop_and_check(input string tag);
        int f0;
        @(negedge clk);
        scan_en = 1'b0;
        repeat (600) @(negedge clk);
        chk(frames == samples + 1, "R5 first result discarded", samples, frames - 1);
        f0 = frames;
        repeat (400) @(negedge clk);
        chk(frames == f0 && cs_n == 1'b1, "R9 no frame after disable", frames, f0);
        $display("session %s: %0d frames, %0d samples", tag, frames, samples);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
        chk(cclk == 1'b0, "R1 cclk in reset", int'(cclk), 0);
        chk(smp_valid == 1'b0, "R1 valid in reset", int'(smp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 idle before enable", int'(cs_n), 1);
    endtask

    task automatic test_counted();
        start_session(1'b0, 1'b0, 5);
        wait_samples(12);
        chk(max_int == 2 * DIV, "R3 rise spacing", max_int, 2 * DIV);
        stop_and_check("counted");
    endtask

    task automatic test_split();
        start_session(1'b0, 1'b1, 700);
        wait_samples(11);
        chk(max_int == (GAP + 2) * DIV, "R8 byte gap length", max_int, (GAP + 2) * DIV);
        stop_and_check("split");
    endtask

    task automatic test_eoc();
        start_session(1'b1, 1'b0, 1000);
        wait_samples(14);
        stop_and_check("flag");
    endtask

    task automatic test_disable_midframe();
        start_session(1'b0, 1'b0, 333);
        wait_samples(3);
        while (cs_n) @(negedge clk);
        repeat (10) @(negedge clk);
        scan_en = 1'b0;
        repeat (600) @(negedge clk);
        chk(samples == 4, "R9 interrupted frame published", samples, 4);
        chk(frames == 5, "R9 frame completed", frames, 5);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R9 stopped idle", int'(cs_n), 1);
        // Re-enable: scan restarts at channel 0 with a discarded first result.
        start_session(1'b0, 1'b1, 77);
        wait_samples(2);
        stop_and_check("restart R9");
    endtask

    initial begin
        test_reset();
        test_counted();
        test_split();
        test_eoc();
        test_disable_midframe();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule